// File: doc/BRIEF.md
# Multi-Lane Serial Flash Transfer Sequencer

This block moves one half-duplex transfer between a pair of byte FIFOs and a serial flash device. Software sets a direction, a lane-mode code, a fragment flag and a chip-select index, then launches the transfer with a single count write (`start` with `cfg_count`). The engine then runs by itself. In transmit direction it pops bytes from the write FIFO and shifts them out most significant bit first over one, two or four data lanes. In receive direction it assembles bytes from the lanes and pushes them into the read FIFO.

The serial clock follows SPI mode 0. It idles low, and data is sampled on its rising edge. It is derived from the core clock by a phase counter, so one serial period spans `CLK_DIV` core cycles (four by default). Chip select is asserted when a transfer starts. At the end of a transfer it is released unless the fragment flag was set, so one flash command can span several count writes. Flow control applies at byte boundaries. The clock stops while the write FIFO has nothing to give, or while the read FIFO cannot take a finished byte. A one-cycle `done` pulse marks the end of every transfer.

Top module: `spi_xfer_seq`

## Requirements
- R1: `start` is accepted only while the engine is idle. It latches `cfg_dir`, `cfg_lanes`, `cfg_frag`, `cfg_cs` and `cfg_count`. A `start` pulse or configuration change during a transfer has no effect on the bytes moved or on the timing.
- R2: In transmit direction (`cfg_dir`=1), each byte is sent most significant bit first. The lane-mode code selects the width. Code 3 gives quad: each serial clock carries four bits on `io_out[3:0]`, with `io_out[3]` the most significant. Code 2 gives dual: `io_out[1:0]`, with `io_out[1]` the most significant. Every other code (0, 1, 4 to 7) gives single: one bit per clock on `io_out[0]`.
- R3: In receive direction (`cfg_dir`=0), bits are taken at the rising serial clock edge. The lane mapping is the same as R2, except that single mode reads `io_in[1]`. Each completed byte is offered on `rx_data` with `rx_valid`.
- R4: `io_oe` is 4'b0001 for single transmit, 4'b0011 for dual transmit and 4'b1111 for quad transmit. It is 4'b0000 in receive direction and while idle.
- R5: `sclk` is low while idle and between bytes. Each serial period is `CLK_DIV` core cycles, low for the first half and high for the second. A byte takes exactly 8/width rising edges.
- R6: `cfg_cs`=k drives `cs_n[k]` low. The other chip selects stay high, and at most one is ever low.
- R7: When `cfg_frag`=0, chip select is released (all `cs_n` high) in the cycle after `done`. When `cfg_frag`=1, it stays asserted after `done` and through the idle gap that follows.
- R8: `done` is a single-cycle pulse. The `start` edge counts as cycle 0. With no flow-control stalls, `done` is high in cycle N·((8/width)·`CLK_DIV`+1)+1 for an N-byte transmit and in cycle N·((8/width)·`CLK_DIV`+2)+1 for an N-byte receive.
- R9: A count of zero produces `done` in cycle 0 and no serial clock edge.
- R10: A transmit transfer whose write FIFO is empty at a byte boundary holds `sclk` low until a byte is available. No bit is sent for a missing byte.
- R11: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high, `rx_data` stays stable and `sclk` stays low.
- R12: `tx_pop` is only ever high together with `tx_valid`. There is exactly one pop per transmitted byte, and none in receive direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Count write strobe that launches a transfer |
| cfg_dir | input | 1 | 1 = transmit, 0 = receive |
| cfg_lanes | input | 3 | Lane-mode code (3 quad, 2 dual, others single) |
| cfg_frag | input | 1 | Keep chip select asserted after this transfer |
| cfg_cs | input | CS_W | Chip-select index |
| cfg_count | input | CNT_W | Number of bytes to move |
| tx_valid | input | 1 | Write FIFO has a byte |
| tx_data | input | BYTE_W | Head byte of the write FIFO |
| tx_pop | output | 1 | Write FIFO pop |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | BYTE_W | Received byte |
| rx_ready | input | 1 | Read FIFO can accept a byte |
| sclk | output | 1 | Serial clock, mode 0 |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Data lane outputs |
| io_oe | output | 4 | Data lane output enables |
| io_in | input | 4 | Data lane inputs |
| done | output | 1 | Transfer complete pulse |

## Verification
The `done` pulse is due a fixed number of cycles after the `start` edge: per byte, one load cycle plus `CLK_DIV` cycles per lane group, plus one push cycle in receive direction, plus one finish cycle. The bench counts falling edges from `start` and compares the count with that formula whenever stalls are disabled. Serial data is checked at each rising `sclk` edge seen at a falling core-clock edge, because the lanes hold their value through the high half-period. FIFO handshakes are decided at the falling edge and read back one delta later, so every pop and push is attributed to the following rising edge. The chip-select state after a transfer is checked one cycle after `done`, which is the cycle in which a release becomes visible.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SHIFT,
      ST_PUSH,
      ST_FINISH
   } seq_state_t;

   typedef enum logic [1:0] {
      LW_ONE  = 2'd0,
      LW_TWO  = 2'd1,
      LW_FOUR = 2'd2
   } lane_sel_t;

   localparam int LANES = 4;

   // lane-mode code: 3 quad, 2 dual, anything else single
   function automatic lane_sel_t decode_lanes(input logic [2:0] code);
      case (code)
         3'd2:    return LW_TWO;
         3'd3:    return LW_FOUR;
         default: return LW_ONE;
      endcase
   endfunction

endpackage

// File: rtl/spi_seq_phase.sv
module spi_seq_phase #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic sample,
   output logic last
);
   localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int HALF = CLK_DIV / 2;

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("spi_seq_phase: CLK_DIV must be even and at least 2");
   end

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph_q <= '0;
      else if (!run || ph_q == PH_W'(CLK_DIV - 1))
         ph_q <= '0;
      else
         ph_q <= ph_q + 1'b1;
   end

   assign sclk   = run && (ph_q >= PH_W'(HALF));
   assign sample = run && (ph_q == PH_W'(HALF));
   assign last   = run && (ph_q == PH_W'(CLK_DIV - 1));

endmodule

// File: rtl/spi_seq_lanes.sv
module spi_seq_lanes
   import spi_seq_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_sel_t         lsel,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              shift_out,
   input  logic              shift_in,
   input  logic [LANES-1:0]  io_in,
   output logic [LANES-1:0]  io_out,
   output logic [LANES-1:0]  lane_mask,
   output logic [BYTE_W-1:0] word
);
   if (BYTE_W < 4 || (BYTE_W % 4) != 0) begin : g_bad_width
      $error("spi_seq_lanes: BYTE_W must be a multiple of 4");
   end

   logic [BYTE_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= load_data;
      end else if (shift_in) begin
         case (lsel)
            LW_FOUR: sh_q <= {sh_q[BYTE_W-5:0], io_in[3:0]};
            LW_TWO:  sh_q <= {sh_q[BYTE_W-3:0], io_in[1:0]};
            default: sh_q <= {sh_q[BYTE_W-2:0], io_in[1]};
         endcase
      end else if (shift_out) begin
         case (lsel)
            LW_FOUR: sh_q <= {sh_q[BYTE_W-5:0], 4'b0000};
            LW_TWO:  sh_q <= {sh_q[BYTE_W-3:0], 2'b00};
            default: sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
         endcase
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == 0) begin : g_l0
         assign io_out[i]    = (lsel == LW_FOUR) ? sh_q[BYTE_W-4] :
                               (lsel == LW_TWO)  ? sh_q[BYTE_W-2] : sh_q[BYTE_W-1];
         assign lane_mask[i] = 1'b1;
      end else if (i == 1) begin : g_l1
         assign io_out[i]    = (lsel == LW_FOUR) ? sh_q[BYTE_W-3] :
                               (lsel == LW_TWO)  ? sh_q[BYTE_W-1] : 1'b0;
         assign lane_mask[i] = (lsel == LW_FOUR) || (lsel == LW_TWO);
      end else begin : g_lhi
         assign io_out[i]    = (lsel == LW_FOUR) ? sh_q[BYTE_W-4+i] : 1'b0;
         assign lane_mask[i] = (lsel == LW_FOUR);
      end
   end

   assign word = sh_q;

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
   import spi_seq_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int CLK_DIV = 4,
   parameter int NUM_CS  = 2,
   parameter int BYTE_W  = 8,
   localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cfg_dir,
   input  logic [2:0]        cfg_lanes,
   input  logic              cfg_frag,
   input  logic [CS_W-1:0]   cfg_cs,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              tx_valid,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              tx_pop,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_data,
   input  logic              rx_ready,
   output logic              sclk,
   output logic [NUM_CS-1:0] cs_n,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in,
   output logic              done
);
   localparam int GRP_W    = $clog2(BYTE_W);
   localparam int GRP_ONE  = BYTE_W - 1;
   localparam int GRP_TWO  = BYTE_W / 2 - 1;
   localparam int GRP_FOUR = BYTE_W / 4 - 1;

   if (NUM_CS < 1 || CNT_W < 1) begin : g_bad_cfg
      $error("spi_xfer_seq: NUM_CS and CNT_W must be positive");
   end

   seq_state_t       state_q;
   logic             dir_q;
   lane_sel_t        lsel_q;
   logic             frag_q;
   logic [CS_W-1:0]  csidx_q;
   logic             cs_on_q;
   logic [CNT_W-1:0] rem_q;
   logic [GRP_W-1:0] grp_q;

   logic run, ph_sample, ph_last, rd_begin, more;
   logic [LANES-1:0] mask;

   function automatic logic [GRP_W-1:0] grp_init(input lane_sel_t s);
      case (s)
         LW_FOUR: return GRP_W'(GRP_FOUR);
         LW_TWO:  return GRP_W'(GRP_TWO);
         default: return GRP_W'(GRP_ONE);
      endcase
   endfunction

   assign more     = (rem_q != '0);
   assign run      = (state_q == ST_SHIFT);
   assign tx_pop   = (state_q == ST_LOAD) && dir_q && more && tx_valid;
   assign rd_begin = (state_q == ST_LOAD) && !dir_q && more;
   assign rx_valid = (state_q == ST_PUSH);
   assign done     = (state_q == ST_FINISH);
   assign io_oe    = (dir_q && state_q != ST_IDLE) ? mask : '0;

   spi_seq_phase #(.CLK_DIV(CLK_DIV)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .sclk   (sclk),
      .sample (ph_sample),
      .last   (ph_last)
   );

   spi_seq_lanes #(.BYTE_W(BYTE_W)) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .lsel      (lsel_q),
      .load      (tx_pop),
      .load_data (tx_data),
      .shift_out (ph_last && dir_q),
      .shift_in  (ph_sample && !dir_q),
      .io_in     (io_in),
      .io_out    (io_out),
      .lane_mask (mask),
      .word      (rx_data)
   );

   for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
      assign cs_n[c] = !(cs_on_q && (csidx_q == CS_W'(c)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dir_q   <= 1'b0;
         lsel_q  <= LW_ONE;
         frag_q  <= 1'b0;
         csidx_q <= '0;
         cs_on_q <= 1'b0;
         rem_q   <= '0;
         grp_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               dir_q   <= cfg_dir;
               lsel_q  <= decode_lanes(cfg_lanes);
               frag_q  <= cfg_frag;
               csidx_q <= cfg_cs;
               cs_on_q <= 1'b1;
               rem_q   <= cfg_count;
               state_q <= (cfg_count == '0) ? ST_FINISH : ST_LOAD;
            end
            ST_LOAD: begin
               if (!more) begin
                  state_q <= ST_FINISH;
               end else if (tx_pop || rd_begin) begin
                  grp_q   <= grp_init(lsel_q);
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: if (ph_last) begin
               if (grp_q == '0) begin
                  if (dir_q) begin
                     rem_q   <= rem_q - 1'b1;
                     state_q <= ST_LOAD;
                  end else begin
                     state_q <= ST_PUSH;
                  end
               end else begin
                  grp_q <= grp_q - 1'b1;
               end
            end
            ST_PUSH: if (rx_ready) begin
               rem_q   <= rem_q - 1'b1;
               state_q <= ST_LOAD;
            end
            ST_FINISH: begin
               if (!frag_q) cs_on_q <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_xfer_seq_chk.sv
module spi_xfer_seq_chk
   import spi_seq_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input seq_state_t        state,
   input logic              dir,
   input logic              sclk,
   input logic [NUM_CS-1:0] cs_n,
   input logic              done,
   input logic              tx_valid,
   input logic              tx_pop,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic [BYTE_W-1:0] rx_data,
   input logic [3:0]        io_oe
);
   AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1); // R6
   AST_SCLK_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $countones(~cs_n) == 1); // R5
   AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sclk); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> tx_valid && dir); // R12
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && !sclk); // R11
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !dir |-> io_oe == 4'b0000); // R4
   AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_LOAD && dir && !tx_valid |=> !sclk); // R10
endmodule

bind spi_xfer_seq spi_xfer_seq_chk #(.NUM_CS(NUM_CS), .BYTE_W(BYTE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state_q),
   .dir      (dir_q),
   .sclk     (sclk),
   .cs_n     (cs_n),
   .done     (done),
   .tx_valid (tx_valid),
   .tx_pop   (tx_pop),
   .rx_valid (rx_valid),
   .rx_ready (rx_ready),
   .rx_data  (rx_data),
   .io_oe    (io_oe)
);

// File: tb/tb_spi_xfer_seq.sv
`timescale 1ns/1ps
module tb_spi_xfer_seq;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       cfg_dir = 1'b0;
   logic [2:0] cfg_lanes = 3'd1;
   logic       cfg_frag = 1'b0;
   logic [0:0] cfg_cs = 1'b0;
   logic [15:0] cfg_count = '0;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_pop;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       rx_ready = 1'b0;
   logic       sclk;
   logic [1:0] cs_n;
   logic [3:0] io_out, io_oe;
   logic [3:0] io_in = '0;
   logic       done;

   int total = 0;
   int bad = 0;
   logic [7:0] dbuf [16];

   always #10 clk = ~clk;

   spi_xfer_seq #(.CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_dir(cfg_dir),
      .cfg_lanes(cfg_lanes), .cfg_frag(cfg_frag), .cfg_cs(cfg_cs),
      .cfg_count(cfg_count), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_pop(tx_pop), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_ready(rx_ready), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
      .io_oe(io_oe), .io_in(io_in), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic int lane_w(input int code);
      return (code == 3) ? 4 : (code == 2) ? 2 : 1;
   endfunction

   function automatic logic [3:0] oe_mask(input int w);
      return (w == 4) ? 4'b1111 : (w == 2) ? 4'b0011 : 4'b0001;
   endfunction

   function automatic logic [1:0] cs_exp(input int cs);
      return (cs == 0) ? 2'b10 : 2'b01;
   endfunction

   function automatic logic [3:0] in_group(input int g, input int w, input int n);
      int gpb;
      logic [7:0] b;
      logic [3:0] v;
      gpb = 8 / w;
      if (g >= n * gpb) return 4'b0000;
      b = dbuf[g / gpb] >> (8 - w * ((g % gpb) + 1));
      v = b[3:0];
      if (w == 1) return {2'b00, v[0], 1'b0};
      if (w == 2) return {2'b00, v[1:0]};
      return v;
   endfunction

   task automatic xfer(input bit dir, input int code, input bit frag, input int cs,
                       input int n, input int tx_pct, input int rx_pct,
                       input int tx_hold, input bit poke);
      int w, gpb, kk, rises, falls, grpcnt, wbytes, rbytes, pops, tx_idx, it;
      logic [7:0] acc, held;
      bit prev, pend, got;
      w = lane_w(code); gpb = 8 / w; kk = gpb * DIV;
      rises = 0; falls = 0; grpcnt = 0; wbytes = 0; rbytes = 0; pops = 0; tx_idx = 0;
      acc = '0; held = '0; prev = 1'b0; pend = 1'b0; got = 1'b0;
      for (int i = 0; i < 16; i++) dbuf[i] = 8'($urandom);
      io_in = dir ? 4'b0000 : in_group(0, w, n);
      cfg_dir = dir; cfg_lanes = 3'(code); cfg_frag = frag; cfg_cs = 1'(cs);
      cfg_count = 16'(n); start = 1'b1;
      for (it = 0; it < 20000; it++) begin
         @(negedge clk);
         if (it == 0) start = 1'b0;
         if (poke && it == 5) begin start = 1'b1; cfg_count = 16'd3; cfg_dir = ~dir; end
         if (poke && it == 6) begin start = 1'b0; cfg_dir = dir; end
         if (sclk && !prev) begin
            rises++;
            chk(cs_n == cs_exp(cs), "R6 cs_n at sclk rise", cs_n, cs_exp(cs));
            chk(io_oe == (dir ? oe_mask(w) : 4'b0000), "R4 io_oe", io_oe,
                dir ? oe_mask(w) : 4'b0000);
            if (dir) begin
               acc = (w == 4) ? {acc[3:0], io_out} :
                     (w == 2) ? {acc[5:0], io_out[1:0]} : {acc[6:0], io_out[0]};
               grpcnt++;
               if (grpcnt == gpb) begin
                  chk(acc == dbuf[wbytes], "R2 transmitted byte", acc, dbuf[wbytes]);
                  wbytes++; grpcnt = 0; acc = '0;
               end
            end
         end
         if (!sclk && prev) begin
            falls++;
            if (!dir) io_in = in_group(falls, w, n);
         end
         prev = sclk;
         if (dir && it < tx_hold)
            chk(sclk == 1'b0, "R10 sclk while write FIFO empty", sclk, 0);
         if (pend)
            chk(rx_valid && rx_data == held && !sclk, "R11 read stall hold", rx_data, held);
         if (done) begin got = 1'b1; break; end
         // drive FIFO sides for the next rising edge
         tx_valid = dir && (tx_idx < n) && (it >= tx_hold) && (($urandom % 100) >= tx_pct);
         tx_data  = dbuf[tx_idx];
         rx_ready = (($urandom % 100) >= rx_pct);
         #1;
         if (tx_pop) begin pops++; tx_idx++; end
         pend = 1'b0;
         if (rx_valid) begin
            if (rx_ready) begin
               chk(rx_data == dbuf[rbytes], "R3 received byte", rx_data, dbuf[rbytes]);
               rbytes++;
            end else begin
               pend = 1'b1; held = rx_data;
            end
         end
      end
      tx_valid = 1'b0; rx_ready = 1'b0;
      chk(got, "R8 done seen", got, 1);
      if (tx_pct == 0 && rx_pct == 0 && tx_hold == 0) begin
         if (n == 0)
            chk(it == 0, "R9 zero count done cycle", it, 0);
         else if (dir)
            chk(it == n * (kk + 1) + 1, "R8 write latency", it, n * (kk + 1) + 1);
         else
            chk(it == n * (kk + 2) + 1, "R8 read latency", it, n * (kk + 2) + 1);
      end
      chk(rises == n * gpb, "R5 sclk rises per transfer", rises, n * gpb);
      if (dir) begin
         chk(wbytes == n, "R2 bytes sent", wbytes, n);
         chk(pops == n, "R12 pops", pops, n);
      end else begin
         chk(rbytes == n, "R3 bytes received", rbytes, n);
         chk(pops == 0, "R12 no pop on read", pops, 0);
      end
      if (poke) chk(rises == n * gpb, "R1 start while busy ignored", rises, n * gpb);
      @(negedge clk);
      chk(done == 1'b0, "R8 done single pulse", done, 0);
      chk(sclk == 1'b0, "R5 sclk idle low", sclk, 0);
      if (frag)
         chk(cs_n == cs_exp(cs), "R7 cs held after fragment", cs_n, cs_exp(cs));
      else
         chk(cs_n == 2'b11, "R7 cs released", cs_n, 2'b11);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL R8 watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5A17);
      repeat (3) @(negedge clk);
      chk(cs_n == 2'b11, "R6 reset cs_n", cs_n, 2'b11);
      chk(sclk == 1'b0, "R5 reset sclk", sclk, 0);
      chk(io_oe == 4'b0000, "R4 reset io_oe", io_oe, 0);
      chk(done == 1'b0 && tx_pop == 1'b0 && rx_valid == 1'b0, "R8 reset outputs", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // directed: every width, both directions, both selects
      xfer(1, 1, 0, 0, 3, 0, 0, 0, 0);
      xfer(1, 2, 0, 1, 2, 0, 0, 0, 0);
      xfer(1, 3, 0, 0, 4, 0, 0, 0, 0);
      xfer(0, 1, 0, 1, 2, 0, 0, 0, 0);
      xfer(0, 2, 0, 0, 3, 0, 0, 0, 0);
      xfer(0, 3, 0, 1, 2, 0, 0, 0, 0);
      // R9 zero count
      xfer(1, 3, 0, 0, 0, 0, 0, 0, 0);
      // R2 unlisted codes fall back to single
      xfer(1, 0, 0, 1, 1, 0, 0, 0, 0);
      xfer(0, 5, 0, 0, 1, 0, 0, 0, 0);
      // R7 fragment: cs held across idle gap, then released
      xfer(1, 3, 1, 1, 2, 0, 0, 0, 0);
      repeat (5) @(negedge clk);
      chk(cs_n == 2'b01, "R7 cs held in idle gap", cs_n, 2'b01);
      xfer(0, 2, 0, 1, 3, 0, 0, 0, 0);
      // R10 empty write FIFO at start, R11 read FIFO back-pressure
      xfer(1, 2, 0, 0, 2, 0, 0, 20, 0);
      xfer(0, 3, 0, 0, 4, 0, 60, 0, 0);
      // R1 start pulse during a transfer
      xfer(1, 3, 0, 1, 2, 0, 0, 0, 1);
      xfer(0, 1, 0, 0, 1, 0, 0, 0, 1);
      // constrained random mix
      for (int k = 0; k < 40; k++) begin
         bit d, f;
         int code, cs, n, tp, rp;
         d = 1'($urandom); f = 1'($urandom); code = int'($urandom % 4);
         cs = int'($urandom % 2); n = int'($urandom % 6);
         tp = (($urandom % 3) == 0) ? 0 : 30;
         rp = (($urandom % 3) == 0) ? 0 : 30;
         xfer(d, code, f, cs, n, tp, rp, 0, 0);
      end
      xfer(1, 1, 0, 0, 1, 0, 0, 0, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule